// File: doc/BRIEF.md
# Two-Descriptor Parallel Port DMA Channel

This block is a single DMA channel that moves bytes between system memory and a byte-wide parallel device port. Software prepares two buffer descriptors, called context A and context B. Each descriptor carries a 32-bit base address, a 12-bit byte count and a flag that marks the final buffer of a job. The engine serves the two descriptors in alternation. It begins with A after reset. While the engine drains or fills one buffer, software can refill the other one.

A descriptor takes part once software sets its valid bit. When the engine finishes a buffer, it clears that valid bit, raises the sticky done interrupt of that context and turns to the other context. If the other context is not valid, the engine waits without error until software sets the bit. After a buffer flagged as final has drained, the engine sends a one-cycle terminal-count pulse to the device. The engine checks each descriptor before it makes any memory access. A descriptor that would run across a 4 KiB page, or a device-to-memory buffer that does not start on a 64-byte boundary, raises the memory-error interrupt and halts the channel. The channel stays halted until software pulses the channel reset.

Software reaches the block through a small register port with four 64-bit words: descriptor A, descriptor B, control/status and diagnostics. On the memory side the block issues one byte request at a time and holds it until the acknowledge arrives. On the device side it uses a valid/ready byte stream in each direction.

Top module: `pp_dma`

## Requirements
- R1: After reset the control/status and diagnostic words read 0, all three interrupts and the terminal-count output are low, and no memory request or device handshake is offered.
- R2: Register select 0 holds descriptor A and select 1 holds descriptor B. In each descriptor, bits 31:0 are the base address, bits 43:32 are the byte count and bit 63 is the final-buffer flag. Bits 62:44 read back as 0.
- R3: The control/status word (select 2) has these bits: bit 0 direction (0 memory to device, 1 device to memory), bit 1 enable, bit 2 channel reset, bit 3 valid B and bit 4 valid A (writing 1 sets the bit, writing 0 has no effect), and bits 5, 6 and 7 for done A, done B and memory error. Bits 5 to 7 are sticky and are cleared by writing 1. Reads return the current state.
- R4: In memory-to-device mode the engine reads addresses base through base+count-1 in ascending order and presents each byte on the outgoing stream in that order.
- R5: In device-to-memory mode each byte accepted from the incoming stream is written to the next ascending address, starting at base.
- R6: When a buffer completes, the engine clears the valid bit of its context, sets the done flag of that context and moves to the other context. It then processes that context at once if it is valid.
- R7: If the next context is not valid, the engine stays idle, makes no memory request and raises no error, and it resumes once the valid bit is set.
- R8: After the last byte of a buffer flagged as final, dev_tc is high for exactly one cycle, in the cycle after that byte's handshake. A buffer without the flag produces no pulse.
- R9: A descriptor for which base[11:0] + count > 4096, or a device-to-memory descriptor with base[5:0] not 0, sets the memory-error flag and halts the channel before any memory request. A buffer that ends exactly at a page edge is accepted.
- R10: With enable at 0, the channel offers no device handshake and starts no memory request. Once enable returns to 1, it continues from the byte where it stopped.
- R11: The diagnostic word (select 3) reports the current context in bit 0 (0 = A), enable-and-active in bit 1, and the bytes still to transfer in bits 13:2.
- R12: While the channel-reset bit is 1, the valid bits and all three flags are cleared and the engine returns to idle on context A.
- R13: A memory request keeps its address, write flag and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 ctx A, 1 ctx B, 2 control/status, 3 diagnostics) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| dev_out_valid | output | 1 | Outgoing byte available |
| dev_out_data | output | 8 | Outgoing byte |
| dev_out_ready | input | 1 | Device accepts outgoing byte |
| dev_in_valid | input | 1 | Incoming byte available |
| dev_in_data | input | 8 | Incoming byte |
| dev_in_ready | output | 1 | Engine accepts incoming byte |
| dev_tc | output | 1 | Terminal-count pulse after a final buffer |
| irq_a_done | output | 1 | Context A done, sticky |
| irq_b_done | output | 1 | Context B done, sticky |
| irq_mem_err | output | 1 | Descriptor fault, sticky |

## Verification
The bench builds the block with its default page size of 4096 bytes and input alignment of 64 bytes. With these defaults, short buffers placed a few bytes below a page edge exercise both the accept and the reject side of the page check, and one misaligned input base exercises the alignment fault. The memory model's acknowledge latency is raised for the input test, so requests have to wait for several cycles. The tests cover the ping-pong order, the terminal-count placement, idling on an empty next context and freezing in the middle of a buffer.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int CTX_W  = 64;
    localparam int BASE_W = 32;
    localparam int LEN_W  = 12;
    localparam int BYTE_W = 8;
    localparam int RSVD_W = CTX_W - 1 - LEN_W - BASE_W;
    localparam int SPAN_W = BASE_W + 1;
    localparam int PAGE_BITS_DEF = 12;
    localparam int IN_ALIGN_DEF  = 6;

    // register selects
    localparam logic [1:0] SEL_A    = 2'd0;
    localparam logic [1:0] SEL_B    = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_DIAG = 2'd3;

    // control/status bit positions
    localparam int CB_DIR   = 0;
    localparam int CB_EN    = 1;
    localparam int CB_RST   = 2;
    localparam int CB_VB    = 3;
    localparam int CB_VA    = 4;
    localparam int CB_DNA   = 5;
    localparam int CB_DNB   = 6;
    localparam int CB_MERR  = 7;

    typedef struct packed {
        logic              last;
        logic [RSVD_W-1:0] rsvd;
        logic [LEN_W-1:0]  len;
        logic [BASE_W-1:0] base;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_PUSH, ST_PULL, ST_WR, ST_HALT
    } eng_st_e;

    typedef struct packed {
        logic done;
        logic ctx;
        logic fault;
    } eng_evt_t;

    function automatic desc_t clean_desc(input logic [CTX_W-1:0] w);
        desc_t d;
        d = desc_t'(w);
        d.rsvd = '0;
        return d;
    endfunction

    // True when the buffer leaves its page or an inbound base is misaligned.
    function automatic logic desc_fault(input desc_t d, input logic to_mem,
                                        input int unsigned page_bits,
                                        input int unsigned align_bits);
        logic [BASE_W-1:0] pmask;
        logic [BASE_W-1:0] amask;
        logic [SPAN_W-1:0] span;
        pmask = (BASE_W'(1) << page_bits) - BASE_W'(1);
        amask = (BASE_W'(1) << align_bits) - BASE_W'(1);
        span  = {1'b0, d.base & pmask} + SPAN_W'(d.len);
        return (span > (SPAN_W'(1) << page_bits)) ||
               (to_mem && ((d.base & amask) != '0));
    endfunction

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [CTX_W-1:0]  wr_data,
    output logic [CTX_W-1:0]  rd_data,
    input  eng_evt_t          evt,
    input  logic              cur_ctx,
    input  logic              busy,
    input  logic [LEN_W-1:0]  left,
    output desc_t             desc_a,
    output desc_t             desc_b,
    output logic              dir,
    output logic              en,
    output logic              chan_rst,
    output logic [1:0]        valid,
    output logic [1:0]        done,
    output logic              err
);

    logic wr_ctrl;
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_a   <= '0;
            desc_b   <= '0;
            dir      <= 1'b0;
            en       <= 1'b0;
            chan_rst <= 1'b0;
            valid    <= '0;
            done     <= '0;
            err      <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_A) desc_a <= clean_desc(wr_data);
            if (wr_en && sel == SEL_B) desc_b <= clean_desc(wr_data);
            if (wr_ctrl) begin
                dir      <= wr_data[CB_DIR];
                en       <= wr_data[CB_EN];
                chan_rst <= wr_data[CB_RST];
                if (wr_data[CB_VA])   valid[0] <= 1'b1;
                if (wr_data[CB_VB])   valid[1] <= 1'b1;
                if (wr_data[CB_DNA])  done[0]  <= 1'b0;
                if (wr_data[CB_DNB])  done[1]  <= 1'b0;
                if (wr_data[CB_MERR]) err      <= 1'b0;
            end
            if (evt.done) begin
                valid[evt.ctx] <= 1'b0;
                done[evt.ctx]  <= 1'b1;
            end
            if (evt.fault) err <= 1'b1;
            if (chan_rst) begin
                valid <= '0;
                done  <= '0;
                err   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_A:    rd_data = desc_a;
            SEL_B:    rd_data = desc_b;
            SEL_CTRL: rd_data = CTX_W'({err, done[1], done[0], valid[0],
                                        valid[1], chan_rst, en, dir});
            default:  rd_data = CTX_W'({left, busy, cur_ctx});
        endcase
    end

endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int PAGE_BITS     = PAGE_BITS_DEF,
    parameter int IN_ALIGN_BITS = IN_ALIGN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  logic              en,
    input  logic              dir,
    input  logic [1:0]        valid,
    input  desc_t             desc_a,
    input  desc_t             desc_b,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BASE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              dev_out_valid,
    output logic [BYTE_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [BYTE_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output eng_evt_t          evt,
    output logic              cur_ctx,
    output logic              busy,
    output logic [LEN_W-1:0]  left
);

    eng_st_e           st_q, st_n;
    logic              cur_q, cur_n;
    logic [BASE_W-1:0] addr_q, addr_n;
    logic [LEN_W-1:0]  cnt_q, cnt_n;
    logic              last_q, last_n, dir_q, dir_n, tc_q;
    logic [BYTE_W-1:0] data_q, data_n;
    desc_t             sel;
    logic              step, fin, fin_tc;
    logic              unused_rsvd;

    assign unused_rsvd = ^sel.rsvd;

    always_comb begin
        st_n   = st_q;
        cur_n  = cur_q;
        addr_n = addr_q;
        cnt_n  = cnt_q;
        last_n = last_q;
        dir_n  = dir_q;
        data_n = data_q;
        evt    = '0;
        step   = 1'b0;
        fin    = 1'b0;
        fin_tc = 1'b0;
        sel    = cur_q ? desc_b : desc_a;
        case (st_q)
            ST_IDLE: if (en && valid[cur_q]) begin
                if (desc_fault(sel, dir, PAGE_BITS, IN_ALIGN_BITS)) begin
                    evt.fault = 1'b1;
                    st_n      = ST_HALT;
                end else if (sel.len == '0) begin
                    fin = 1'b1;
                end else begin
                    addr_n = sel.base;
                    cnt_n  = sel.len;
                    last_n = sel.last;
                    dir_n  = dir;
                    st_n   = dir ? ST_PULL : ST_RD;
                end
            end
            ST_RD: if (mem_ack) begin
                data_n = mem_rdata;
                st_n   = ST_PUSH;
            end
            ST_PUSH: step = en && dev_out_ready;
            ST_PULL: if (en && dev_in_valid) begin
                data_n = dev_in_data;
                st_n   = ST_WR;
            end
            ST_WR:   step = mem_ack;
            default: ;
        endcase
        if (step) begin
            addr_n = addr_q + BASE_W'(1);
            cnt_n  = cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) begin
                fin    = 1'b1;
                fin_tc = last_q;
            end else begin
                st_n = dir_q ? ST_PULL : ST_RD;
            end
        end
        if (fin) begin
            evt.done = 1'b1;
            evt.ctx  = cur_q;
            cur_n    = ~cur_q;
            st_n     = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
            dir_q  <= 1'b0;
            data_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            cur_q  <= cur_n;
            addr_q <= addr_n;
            cnt_q  <= cnt_n;
            last_q <= last_n;
            dir_q  <= dir_n;
            data_q <= data_n;
            tc_q   <= fin_tc;
        end
    end

    assign mem_req       = (st_q == ST_RD) || (st_q == ST_WR);
    assign mem_we        = (st_q == ST_WR);
    assign mem_addr      = addr_q;
    assign mem_wdata     = data_q;
    assign dev_out_valid = (st_q == ST_PUSH) && en;
    assign dev_out_data  = data_q;
    assign dev_in_ready  = (st_q == ST_PULL) && en;
    assign dev_tc        = tc_q;
    assign cur_ctx       = cur_q;
    assign busy          = en && (st_q != ST_IDLE) && (st_q != ST_HALT);
    assign left          = cnt_q;

endmodule

// File: rtl/pp_dma.sv
module pp_dma
    import pp_dma_pkg::*;
#(
    parameter int PAGE_BITS     = PAGE_BITS_DEF,
    parameter int IN_ALIGN_BITS = IN_ALIGN_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    output logic        dev_out_valid,
    output logic [7:0]  dev_out_data,
    input  logic        dev_out_ready,
    input  logic        dev_in_valid,
    input  logic [7:0]  dev_in_data,
    output logic        dev_in_ready,
    output logic        dev_tc,
    output logic        irq_a_done,
    output logic        irq_b_done,
    output logic        irq_mem_err
);

    desc_t            desc_a, desc_b;
    eng_evt_t         evt;
    logic             chan_dir, chan_en, chan_rst, cur_ctx, busy, err;
    logic [1:0]       valid, done;
    logic [LEN_W-1:0] left;

    pp_dma_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .evt(evt),
        .cur_ctx(cur_ctx), .busy(busy), .left(left),
        .desc_a(desc_a), .desc_b(desc_b), .dir(chan_dir), .en(chan_en),
        .chan_rst(chan_rst), .valid(valid), .done(done), .err(err)
    );

    pp_dma_engine #(.PAGE_BITS(PAGE_BITS), .IN_ALIGN_BITS(IN_ALIGN_BITS)) u_eng (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .en(chan_en),
        .dir(chan_dir), .valid(valid), .desc_a(desc_a), .desc_b(desc_b),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_tc(dev_tc), .evt(evt), .cur_ctx(cur_ctx), .busy(busy),
        .left(left)
    );

    assign irq_a_done  = done[0];
    assign irq_b_done  = done[1];
    assign irq_mem_err = err;

endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        chan_rst,
    input logic        chan_en,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [63:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        dev_out_valid,
    input logic        dev_in_ready,
    input logic        dev_tc,
    input logic        irq_a_done,
    input logic        irq_b_done,
    input logic        irq_mem_err
);

    logic clr_a, clr_b;
    assign clr_a = reg_wr && (reg_addr == 2'd2) && reg_wdata[5];
    assign clr_b = reg_wr && (reg_addr == 2'd2) && reg_wdata[6];

    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst || chan_rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    a_r8_tc_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dev_tc |=> !dev_tc);

    a_r10_frozen_quiet: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> !dev_out_valid && !dev_in_ready);

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        irq_mem_err |-> !mem_req && !dev_out_valid && !dev_in_ready);

    a_r3_done_a_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_a_done && !chan_rst && !clr_a |=> irq_a_done);

    a_r3_done_b_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_b_done && !chan_rst && !clr_b |=> irq_b_done);

endmodule

bind pp_dma pp_dma_chk u_chk (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .chan_en(chan_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .dev_out_valid(dev_out_valid), .dev_in_ready(dev_in_ready),
    .dev_tc(dev_tc), .irq_a_done(irq_a_done), .irq_b_done(irq_b_done),
    .irq_mem_err(irq_mem_err)
);

// File: tb/pp_dma_test.sv
`timescale 1ns/1ps
module pp_dma_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        dev_out_valid;
    logic [7:0]  dev_out_data;
    logic        dev_out_ready = 1'b1;
    logic        dev_in_valid = 1'b0;
    logic [7:0]  dev_in_data = '0;
    logic        dev_in_ready, dev_tc, irq_a_done, irq_b_done, irq_mem_err;

    always #4 clk = ~clk;

    pp_dma uut (.*);

    int checks = 0, fails = 0;
    logic [7:0]  sink_q [0:63];
    int          sink_n = 0;
    logic [31:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    int wlog_n = 0, ack_cnt = 0, mem_lat = 0, wait_c = 0, hold_viol = 0;
    int tc_rise = 0, tc_hi = 0, tc_snap = 0, src_i = 0;
    logic src_on = 1'b0, prev_req = 1'b0, prev_ack = 1'b0, prev_tc = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [63:0] rv;

    // Memory, device sink, device source and pulse monitor, all at negedge.
    initial forever begin
        @(negedge clk);
        if (mem_req && prev_req && !prev_ack && mem_addr != prev_addr) hold_viol++;
        if (mem_req && !mem_ack) begin
            if (wait_c >= mem_lat) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_addr[7:0] ^ 8'hA5;
                if (mem_we && wlog_n < 16) begin
                    wlog_a[wlog_n] = mem_addr;
                    wlog_d[wlog_n] = mem_wdata;
                    wlog_n++;
                end
                ack_cnt++;
                wait_c = 0;
            end else wait_c++;
        end else mem_ack = 1'b0;
        prev_req = mem_req; prev_ack = mem_ack; prev_addr = mem_addr;
        if (dev_out_valid && dev_out_ready && sink_n < 64) begin
            sink_q[sink_n] = dev_out_data;
            sink_n++;
        end
        if (src_on && dev_in_ready) begin
            dev_in_valid = 1'b1;
            dev_in_data  = 8'h30 + 8'(src_i);
            src_i++;
        end else dev_in_valid = 1'b0;
        if (dev_tc) begin
            tc_hi++;
            if (!prev_tc) begin tc_rise++; tc_snap = sink_n; end
        end
        prev_tc = dev_tc;
    end

    function automatic logic [63:0] desc(input logic [31:0] b, input int n, input logic l);
        return {l, 19'b0, 12'(n), b};
    endfunction
    function automatic logic [63:0] ctl(input logic d, input logic e, input logic r,
                                        input logic vb, input logic va, input logic [2:0] clr);
        return {56'b0, clr, va, vb, r, e, d};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int which, input string tag);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((which == 0 && irq_a_done) || (which == 1 && irq_b_done)) return;
        end
        chk({tag, " timeout"}, 64'd0, 64'd1);
    endtask

    task automatic t_reset;
        cyc(1);
        chk("R1 ports", {irq_a_done, irq_b_done, irq_mem_err, dev_tc, mem_req,
                         dev_out_valid, dev_in_ready}, 64'd0);
        rd(2'd2, rv); chk("R1 ctrl", rv, 64'd0);
        rd(2'd3, rv); chk("R1 diag", rv, 64'd0);
    endtask

    task automatic t_desc_fmt;
        wr(2'd0, 64'hFFFF_F123_8765_4321);
        wr(2'd1, 64'h7AB0_0456_0000_0010);
        rd(2'd0, rv); chk("R2 ctx A", rv, 64'h8000_0123_8765_4321);
        rd(2'd1, rv); chk("R2 ctx B", rv, 64'h0000_0456_0000_0010);
    endtask

    task automatic t_out_single;
        sink_n = 0; tc_rise = 0;
        wr(2'd0, desc(32'h1000_0010, 5, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 0, 1, 3'b000));
        wait_irq(0, "R4");
        cyc(2);
        chk("R4 count", 64'(sink_n), 64'd5);
        for (int i = 0; i < 5; i++)
            chk("R4 byte", 64'(sink_q[i]), 64'(8'(8'h10 + 8'(i)) ^ 8'hA5));
        rd(2'd2, rv); chk("R3 R6 ctrl after A", rv, 64'h22);
        rd(2'd3, rv); chk("R11 diag after A", rv, 64'd1);
        chk("R8 no pulse without flag", 64'(tc_rise), 64'd0);
    endtask

    task automatic t_pingpong;
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b001));
        sink_n = 0; tc_rise = 0; tc_hi = 0;
        wr(2'd1, desc(32'h1000_0200, 3, 1'b1));
        wr(2'd0, desc(32'h1000_0300, 2, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 1, 1, 3'b000));
        wait_irq(0, "R6");
        cyc(2);
        chk("R6 total bytes", 64'(sink_n), 64'd5);
        for (int i = 0; i < 5; i++)
            chk("R6 order", 64'(sink_q[i]),
                64'((i < 3 ? 8'(i) : 8'(i - 3)) ^ 8'hA5));
        chk("R6 done B", 64'(irq_b_done), 64'd1);
        chk("R8 pulses", 64'(tc_rise), 64'd1);
        chk("R8 width", 64'(tc_hi), 64'd1);
        chk("R8 placement", 64'(tc_snap), 64'd3);
    endtask

    task automatic t_idle;
        int acks;
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b011));
        acks = ack_cnt;
        cyc(20);
        chk("R7 no request", 64'(ack_cnt), 64'(acks));
        chk("R7 no error", 64'(irq_mem_err), 64'd0);
        rd(2'd3, rv); chk("R7 R11 idle diag", rv, 64'd1);
        sink_n = 0;
        wr(2'd1, desc(32'h1000_0400, 2, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 1, 0, 3'b000));
        wait_irq(1, "R7");
        cyc(2);
        chk("R7 resumed", 64'(sink_n), 64'd2);
    endtask

    task automatic t_freeze;
        int frozen;
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b011));
        sink_n = 0;
        wr(2'd0, desc(32'h1000_0500, 6, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 0, 1, 3'b000));
        for (int i = 0; i < 200 && sink_n < 2; i++) @(negedge clk);
        wr(2'd2, ctl(0, 0, 0, 0, 0, 3'b000));
        cyc(4);
        frozen = sink_n;
        cyc(10);
        chk("R10 no progress", 64'(sink_n), 64'(frozen));
        chk("R10 no valid", 64'(dev_out_valid), 64'd0);
        rd(2'd3, rv); chk("R11 bytes left", rv, 64'((6 - frozen) << 2));
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b000));
        wait_irq(0, "R10");
        cyc(2);
        chk("R10 total", 64'(sink_n), 64'd6);
        chk("R10 last byte", 64'(sink_q[5]), 64'(8'h05 ^ 8'hA5));
    endtask

    task automatic t_inbound;
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b011));
        mem_lat = 2; wlog_n = 0; src_i = 0; src_on = 1'b1;
        wr(2'd1, desc(32'h2000_0040, 4, 1'b0));
        wr(2'd2, ctl(1, 1, 0, 1, 0, 3'b000));
        wait_irq(1, "R5");
        src_on = 1'b0; mem_lat = 0;
        cyc(2);
        chk("R5 writes", 64'(wlog_n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 addr", 64'(wlog_a[i]), 64'(32'h2000_0040 + 32'(i)));
            chk("R5 data", 64'(wlog_d[i]), 64'(8'h30 + 8'(i)));
        end
        chk("R13 hold violations", 64'(hold_viol), 64'd0);
    endtask

    task automatic t_fault;
        int acks;
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b111));
        acks = ack_cnt;
        wr(2'd0, desc(32'h3000_0FFE, 4, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 0, 1, 3'b000));
        cyc(5);
        chk("R9 page fault", 64'(irq_mem_err), 64'd1);
        chk("R9 no done", 64'(irq_a_done), 64'd0);
        wr(2'd1, desc(32'h3000_0000, 2, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 1, 0, 3'b000));
        cyc(10);
        chk("R9 halted", 64'(ack_cnt), 64'(acks));
        rd(2'd2, rv); chk("R3 R9 ctrl halted", rv, 64'h9A);
        wr(2'd2, ctl(0, 0, 1, 0, 0, 3'b000));
        wr(2'd2, ctl(0, 0, 0, 0, 0, 3'b000));
        rd(2'd2, rv); chk("R12 ctrl cleared", rv, 64'd0);
        rd(2'd3, rv); chk("R12 diag cleared", rv, 64'd0);
        sink_n = 0;
        wr(2'd0, desc(32'h4000_0FFC, 4, 1'b0));
        wr(2'd2, ctl(0, 1, 0, 0, 1, 3'b000));
        wait_irq(0, "R9 edge");
        cyc(2);
        chk("R9 edge accepted", 64'(sink_n), 64'd4);
        chk("R9 edge no error", 64'(irq_mem_err), 64'd0);
        wr(2'd2, ctl(0, 1, 0, 0, 0, 3'b111));
        wr(2'd1, desc(32'h2000_0041, 4, 1'b0));
        wr(2'd2, ctl(1, 1, 0, 1, 0, 3'b000));
        cyc(5);
        chk("R9 misaligned inbound", 64'(irq_mem_err), 64'd1);
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_desc_fmt();
        t_out_single();
        t_pingpong();
        t_idle();
        t_freeze();
        t_inbound();
        t_fault();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule